// File: doc/BRIEF.md
# Early Branch Resolver for a Five-Stage Pipeline

This block holds the fetch program counter and the fetch-to-decode register of a five-stage pipeline. It settles every control transfer while that transfer sits in decode. For a conditional branch it tests the source register against zero and forms the taken target with its own adder. For a direct jump it takes the target from the instruction's index field, and for a register jump it takes the register value. A taken transfer steers fetch on the very next edge, so only one fetched successor is ever in question.

A parameter fixes what happens to that successor. In squash mode, fetch runs ahead sequentially, and a taken transfer replaces the successor with an all-zero no-operation as it enters decode. In delay-slot mode, the successor always runs. If a branch or register jump reads a register that the execute stage will write, or that a load in the memory stage will return, decode and fetch hold until the operand can be delivered.

All pins are plain per-cycle controls and values. Instruction memory, the register file, operand forwarding and the ALU sit outside the block, so it has no valid/ready stream and no back-pressure beyond its own stall output. The instruction word is sampled every cycle in which `stall` is low.

Top module: `early_branch_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` equals `RESET_PC` (default 0), `rd_we` is 0 and `redirect` is 0.
- R2: With no redirect and no stall, `fetch_pc` rises by 4 on each clock edge.
- R3: Opcode `instr[31:26]` = 0x04 is taken when the register named by `instr[25:21]` is zero. Opcode 0x05 is taken when that register is non-zero. The taken target is `id_pc4 + (sign-extended instr[15:0] << 2)`, and `fetch_pc` takes it on the edge that ends the branch's decode cycle.
- R4: Opcodes 0x02 and 0x03 always redirect, to `{id_pc4[31:28], instr[25:0], 2'b00}`.
- R5: Opcodes 0x06 and 0x07 always redirect, to the value of the register named by `instr[25:21]`.
- R6: Opcodes 0x03 and 0x07 write register 31 (`rd_we`=1, `rd_idx`=31). `link_val` is `id_pc4` in squash mode and `id_pc4 + 4` in delay-slot mode.
- R7: In squash mode, a taken transfer raises `flush`. On the next cycle decode holds the all-zero instruction, which writes no register.
- R8: In delay-slot mode, `flush` stays low and the instruction fetched after a taken transfer reaches decode and performs its register write.
- R9: A decode instruction of opcode 0x04–0x07 stalls when its source matches `ex_rd` with `ex_wr_en` high, or matches `mem_rd` with `mem_load` high. While stalled, `fetch_pc` and the decode instruction hold and no redirect occurs.
- R10: A source of register 0 never causes a stall.
- R11: `rd_we` is 1 for a non-zero opcode 0x00 instruction, which writes `instr[15:11]`, and for opcodes 0x08–0x0F and 0x23, which write `instr[20:16]`. It is 0 for a destination of register 0 and for the other control opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| imem_data | input | 32 | Instruction word at `fetch_pc` |
| fetch_pc | output | 32 | Current fetch address |
| id_instr | output | 32 | Instruction held in decode |
| id_pc4 | output | 32 | Address after the decode instruction |
| rs_val | input | 32 | Forwarded value of the decode source register |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | 5 | Execute-stage destination |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_rd | input | 5 | Memory-stage load destination |
| stall | output | 1 | Hold fetch and decode this cycle |
| redirect | output | 1 | Fetch goes to `target` on this edge |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 jump index, 3 register |
| target | output | 32 | Candidate control-transfer address |
| flush | output | 1 | Wrong-path instruction is being squashed |
| rd_we | output | 1 | Decode instruction writes a register |
| rd_idx | output | 5 | Register it writes |
| link_val | output | 32 | Return address for linking transfers |

## Verification
The two functions that can fall in the same cycle are the hazard stall and branch resolution: a branch sits in decode while its source is still being produced. The bench provokes this by raising an execute-stage write and then a memory-stage load to the branch's register during the cycles that branch occupies decode. It judges the result by the fetched address stream: the address must repeat for exactly those cycles, and the redirect, with its squash or delay slot, must come only after the hazard clears. A register-0 hazard raised under the first branch must leave the stream untouched.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int OP_W   = 6;
  localparam int IMM_W  = 16;
  localparam int JIDX_W = 26;

  localparam logic [OP_W-1:0] OP_ALU  = 6'h00;
  localparam logic [OP_W-1:0] OP_J    = 6'h02;
  localparam logic [OP_W-1:0] OP_JAL  = 6'h03;
  localparam logic [OP_W-1:0] OP_BEQZ = 6'h04;
  localparam logic [OP_W-1:0] OP_BNEZ = 6'h05;
  localparam logic [OP_W-1:0] OP_JR   = 6'h06;
  localparam logic [OP_W-1:0] OP_JALR = 6'h07;
  localparam logic [OP_W-1:0] OP_LOAD = 6'h23;

  typedef enum logic [1:0] {NPC_SEQ, NPC_BRANCH, NPC_JUMP, NPC_REG} npc_sel_e;
  typedef enum logic [2:0] {K_NONE, K_BEQZ, K_BNEZ, K_JUMP, K_JREG} ctl_kind_e;

  typedef struct packed {
    ctl_kind_e           kind;
    logic                reads_rs;
    logic [REG_AW-1:0]   rs;
    logic [IMM_W-1:0]    imm;
    logic [JIDX_W-1:0]   jidx;
    logic                wr_en;
    logic [REG_AW-1:0]   wr_idx;
  } dec_t;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int LINK_REG = 31
) (
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [OP_W-1:0] op;
  assign op = instr[XLEN-1:XLEN-OP_W];

  always_comb begin
    dec          = '0;
    dec.kind     = K_NONE;
    dec.rs       = instr[25:21];
    dec.imm      = instr[IMM_W-1:0];
    dec.jidx     = instr[JIDX_W-1:0];
    dec.reads_rs = 1'b0;
    dec.wr_en    = 1'b0;
    dec.wr_idx   = '0;
    case (op)
      OP_BEQZ: begin dec.kind = K_BEQZ; dec.reads_rs = 1'b1; end
      OP_BNEZ: begin dec.kind = K_BNEZ; dec.reads_rs = 1'b1; end
      OP_J:    dec.kind = K_JUMP;
      OP_JAL: begin
        dec.kind   = K_JUMP;
        dec.wr_en  = 1'b1;
        dec.wr_idx = REG_AW'(LINK_REG);
      end
      OP_JR: begin dec.kind = K_JREG; dec.reads_rs = 1'b1; end
      OP_JALR: begin
        dec.kind     = K_JREG;
        dec.reads_rs = 1'b1;
        dec.wr_en    = 1'b1;
        dec.wr_idx   = REG_AW'(LINK_REG);
      end
      OP_ALU: begin
        dec.wr_idx = instr[15:11];
        dec.wr_en  = (instr != '0) && (instr[15:11] != '0);
      end
      OP_LOAD: begin
        dec.wr_idx = instr[20:16];
        dec.wr_en  = (instr[20:16] != '0);
      end
      default: begin
        if (op[OP_W-1:3] == 3'b001) begin
          dec.wr_idx = instr[20:16];
          dec.wr_en  = (instr[20:16] != '0);
        end
      end
    endcase
  end
endmodule

// File: rtl/bru_hazard.sv
module bru_hazard
  import bru_pkg::*;
(
  input  logic              reads_rs,
  input  logic [REG_AW-1:0] rs,
  input  logic              ex_wr_en,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] mem_rd,
  output logic              stall
);
  logic live_src, ex_hit, mem_hit;

  always_comb begin
    live_src = reads_rs && (rs != '0);
    ex_hit   = ex_wr_en && (ex_rd == rs);
    mem_hit  = mem_load && (mem_rd == rs);
    stall    = live_src && (ex_hit || mem_hit);
  end
endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
  import bru_pkg::*;
#(
  parameter bit DELAY_SLOT = 1'b0
) (
  input  dec_t            dec,
  input  logic [XLEN-1:0] pc4,
  input  logic [XLEN-1:0] rs_val,
  output logic            taken,
  output npc_sel_e        sel,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] link_val
);
  localparam int SEXT_W = XLEN - IMM_W - 2;
  localparam int JHI_W  = XLEN - JIDX_W - 2;

  logic            rs_zero;
  logic [XLEN-1:0] br_tgt, j_tgt;

  assign rs_zero = (rs_val == '0);
  assign br_tgt  = pc4 + {{SEXT_W{dec.imm[IMM_W-1]}}, dec.imm, 2'b00};
  assign j_tgt   = {pc4[XLEN-1:XLEN-JHI_W], dec.jidx, 2'b00};

  always_comb begin
    taken  = 1'b0;
    sel    = NPC_SEQ;
    target = br_tgt;
    case (dec.kind)
      K_BEQZ: begin taken = rs_zero;  sel = NPC_BRANCH; end
      K_BNEZ: begin taken = !rs_zero; sel = NPC_BRANCH; end
      K_JUMP: begin taken = 1'b1; sel = NPC_JUMP; target = j_tgt;  end
      K_JREG: begin taken = 1'b1; sel = NPC_REG;  target = rs_val; end
      default: ;
    endcase
  end

  generate
    if (DELAY_SLOT) begin : g_link_ds
      assign link_val = pc4 + XLEN'(4);
    end else begin : g_link_sq
      assign link_val = pc4;
    end
  endgenerate
endmodule

// File: rtl/early_branch_unit.sv
module early_branch_unit
  import bru_pkg::*;
#(
  parameter logic [31:0] RESET_PC   = 32'h0,
  parameter bit          DELAY_SLOT = 1'b0,
  parameter int          LINK_REG   = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] imem_data,
  output logic [31:0] fetch_pc,
  output logic [31:0] id_instr,
  output logic [31:0] id_pc4,
  input  logic [31:0] rs_val,
  input  logic        ex_wr_en,
  input  logic [4:0]  ex_rd,
  input  logic        mem_load,
  input  logic [4:0]  mem_rd,
  output logic        stall,
  output logic        redirect,
  output logic [1:0]  pc_sel,
  output logic [31:0] target,
  output logic        flush,
  output logic        rd_we,
  output logic [4:0]  rd_idx,
  output logic [31:0] link_val
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q, ir_q, pc4_q;
  dec_t            dec;
  logic            taken, squash;
  npc_sel_e        sel;

  bru_decode #(.LINK_REG(LINK_REG)) u_dec (
    .instr (ir_q),
    .dec   (dec)
  );

  bru_hazard u_haz (
    .reads_rs (dec.reads_rs),
    .rs       (dec.rs),
    .ex_wr_en (ex_wr_en),
    .ex_rd    (ex_rd),
    .mem_load (mem_load),
    .mem_rd   (mem_rd),
    .stall    (stall)
  );

  bru_resolve #(.DELAY_SLOT(DELAY_SLOT)) u_res (
    .dec      (dec),
    .pc4      (pc4_q),
    .rs_val   (rs_val),
    .taken    (taken),
    .sel      (sel),
    .target   (target),
    .link_val (link_val)
  );

  assign redirect = taken && !stall;
  assign pc_sel   = redirect ? sel : NPC_SEQ;

  generate
    if (DELAY_SLOT) begin : g_slot
      assign squash = 1'b0;
    end else begin : g_squash
      assign squash = redirect;
    end
  endgenerate

  assign flush = squash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      pc4_q <= RESET_PC;
    end else if (!stall) begin
      pc_q  <= redirect ? target : pc_q + STEP;
      ir_q  <= squash ? '0 : imem_data;
      pc4_q <= pc_q + STEP;
    end
  end

  assign fetch_pc = pc_q;
  assign id_instr = ir_q;
  assign id_pc4   = pc4_q;
  assign rd_we    = dec.wr_en;
  assign rd_idx   = dec.wr_idx;
endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] fetch_pc,
  input logic [31:0] id_instr,
  input logic [31:0] target,
  input logic        stall,
  input logic        redirect,
  input logic        flush
);
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redirect) |=> (fetch_pc == $past(fetch_pc) + 32'd4));

  assert_redirect_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (fetch_pc == $past(target)));

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fetch_pc == $past(fetch_pc)) && (id_instr == $past(id_instr)));

  assert_squash_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (id_instr == 32'h0));

  assert_flush_needs_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> redirect);

  generate
    if (DELAY_SLOT) begin : g_ds
      assert_slot_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flush);
    end
  endgenerate
endmodule

bind early_branch_unit bru_checker #(.DELAY_SLOT(DELAY_SLOT)) u_bru_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fetch_pc (fetch_pc),
  .id_instr (id_instr),
  .target   (target),
  .stall    (stall),
  .redirect (redirect),
  .flush    (flush)
);

// File: tb/tb_early_branch_unit.sv
`timescale 1ns/1ps
module tb_early_branch_unit;
  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic        st;
    logic        fl;
    logic        lc;
    logic [31:0] link;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_wr_en = 1'b0, mem_load = 1'b0;
  logic [4:0] ex_rd = '0, mem_rd = '0;
  always #2.5 clk = ~clk;

  logic [31:0] p_imem, p_pc, p_id, p_pc4, p_rs, p_tgt, p_link;
  logic        p_st, p_rdir, p_fl, p_we;
  logic [1:0]  p_sel;
  logic [4:0]  p_rdi;
  logic [31:0] d_imem, d_pc, d_id, d_pc4, d_rs, d_tgt, d_link;
  logic        d_st, d_rdir, d_fl, d_we;
  logic [1:0]  d_sel;
  logic [4:0]  d_rdi;

  int checks = 0;
  int fails  = 0;
  logic mon_en = 1'b0;
  exp_t q_p[$];
  exp_t q_d[$];

  function automatic logic [31:0] add_op(input logic [4:0] rd);
    return {6'h00, 5'd1, 5'd2, rd, 11'h020};
  endfunction

  function automatic logic [31:0] prog_word(input logic [31:0] a);
    case (a)
      32'h00: return add_op(5'd3);
      32'h04: return {6'h04, 5'd0, 5'd0, 16'd6};
      32'h08: return add_op(5'd5);
      32'h0C: return add_op(5'd6);
      32'h20: return {6'h05, 5'd1, 5'd0, 16'd10};
      32'h24: return {6'h05, 5'd2, 5'd0, 16'd6};
      32'h28: return add_op(5'd7);
      32'h40: return {6'h03, 26'd24};
      32'h44: return add_op(5'd8);
      32'h60: return {6'h06, 5'd4, 21'd0};
      32'h64: return add_op(5'd9);
      32'h80: return {6'h04, 5'd2, 5'd0, 16'd1};
      32'h84: return add_op(5'd10);
      32'h88: return {6'h04, 5'd0, 5'd0, 16'hFFF9};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] reg_val(input logic [4:0] r);
    case (r)
      5'd2: return 32'd5;
      5'd4: return 32'h80;
      default: return 32'h0;
    endcase
  endfunction

  assign p_imem = prog_word(p_pc);
  assign d_imem = prog_word(d_pc);
  assign p_rs   = reg_val(p_id[25:21]);
  assign d_rs   = reg_val(d_id[25:21]);

  early_branch_unit #(.DELAY_SLOT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .imem_data(p_imem), .fetch_pc(p_pc),
    .id_instr(p_id), .id_pc4(p_pc4), .rs_val(p_rs), .ex_wr_en(ex_wr_en),
    .ex_rd(ex_rd), .mem_load(mem_load), .mem_rd(mem_rd), .stall(p_st),
    .redirect(p_rdir), .pc_sel(p_sel), .target(p_tgt), .flush(p_fl),
    .rd_we(p_we), .rd_idx(p_rdi), .link_val(p_link));

  early_branch_unit #(.DELAY_SLOT(1'b1)) dut_ds (
    .clk(clk), .rst_n(rst_n), .imem_data(d_imem), .fetch_pc(d_pc),
    .id_instr(d_id), .id_pc4(d_pc4), .rs_val(d_rs), .ex_wr_en(ex_wr_en),
    .ex_rd(ex_rd), .mem_load(mem_load), .mem_rd(mem_rd), .stall(d_st),
    .redirect(d_rdir), .pc_sel(d_sel), .target(d_tgt), .flush(d_fl),
    .rd_we(d_we), .rd_idx(d_rdi), .link_val(d_link));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic p(input bit ds, input logic [31:0] pc, input logic we,
                   input logic st, input logic fl, input logic lc,
                   input logic [31:0] lk);
    exp_t e;
    e.pc = pc; e.we = we; e.st = st; e.fl = fl; e.lc = lc; e.link = lk;
    if (ds) q_d.push_back(e); else q_p.push_back(e);
  endtask

  // Expected fetch stream; the squashed or delay-slot successor differs by mode.
  task automatic push_all(input bit ds, input bit st);
    logic fl;
    fl = !ds;
    p(ds, 32'h00, 0, 0, 0, 0, 0);
    p(ds, 32'h04, 1, 0, 0, 0, 0);
    p(ds, 32'h08, 0, 0, fl, 0, 0);
    p(ds, 32'h20, ds, 0, 0, 0, 0);
    p(ds, 32'h24, 0, 0, 0, 0, 0);
    if (st) begin
      p(ds, 32'h28, 0, 1, 0, 0, 0);
      p(ds, 32'h28, 0, 1, 0, 0, 0);
    end
    p(ds, 32'h28, 0, 0, fl, 0, 0);
    p(ds, 32'h40, ds, 0, 0, 0, 0);
    p(ds, 32'h44, 1, 0, fl, 1, ds ? 32'h48 : 32'h44);
    p(ds, 32'h60, ds, 0, 0, 0, 0);
    p(ds, 32'h64, 0, 0, fl, 0, 0);
    p(ds, 32'h80, ds, 0, 0, 0, 0);
    p(ds, 32'h84, 0, 0, 0, 0, 0);
    p(ds, 32'h88, 1, 0, 0, 0, 0);
    p(ds, 32'h8C, 0, 0, fl, 0, 0);
    p(ds, 32'h70, 0, 0, 0, 0, 0);
    p(ds, 32'h74, 0, 0, 0, 0, 0);
  endtask

  task automatic cmp(input string who, input exp_t e, input logic [31:0] pc,
                     input logic we, input logic st, input logic fl,
                     input logic [31:0] lk);
    chk("R2 R3 R4 R5 R9", {who, " fetch_pc"}, pc, e.pc);
    chk("R7 R8 R11", {who, " rd_we"}, {31'd0, we}, {31'd0, e.we});
    chk("R9 R10", {who, " stall"}, {31'd0, st}, {31'd0, e.st});
    chk("R7 R8", {who, " flush"}, {31'd0, fl}, {31'd0, e.fl});
    if (e.lc) chk("R6", {who, " link_val"}, lk, e.link);
  endtask

  // Monitor: pops one expected item per instance each cycle.
  always @(negedge clk) begin
    #2;
    if (mon_en) begin
      if (q_p.size() > 0) cmp("squash", q_p.pop_front(), p_pc, p_we, p_st, p_fl, p_link);
      if (q_d.size() > 0) cmp("delay", q_d.pop_front(), d_pc, d_we, d_st, d_fl, d_link);
    end
  end

  task automatic set_haz(input bit st, input int k);
    ex_wr_en = st && (k == 2 || k == 5);
    ex_rd    = (k == 2) ? 5'd0 : 5'd2;
    mem_load = st && (k == 6);
    mem_rd   = 5'd2;
  endtask

  task automatic run(input bit st);
    int n;
    push_all(1'b0, st);
    push_all(1'b1, st);
    n = q_p.size();
    rst_n = 1'b0;
    set_haz(1'b0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1", "reset fetch_pc", p_pc, 32'h0);
    chk("R1", "reset rd_we/redirect", {30'd0, p_we, p_rdir}, 32'h0);
    chk("R1", "reset delay-mode fetch_pc", d_pc, 32'h0);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    set_haz(st, 0);
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      #1;
      set_haz(st, k);
    end
    @(negedge clk);
    #1;
    mon_en = 1'b0;
    set_haz(1'b0, 0);
    chk("R2", "leftover expectations", q_p.size() + q_d.size(), 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    run(1'b0);   // R3 R4 R5 R6 R7 R8 R11 without hazards
    run(1'b1);   // R9 R10 stall meets branch resolution
    finish_up();
  end
endmodule